// File: doc/BRIEF.md
# Segment Insertion Bit Cell

This block is a one-bit scan cell that lets a test access path grow or shrink while it runs. It sits on the serial scan path driven by a test access port and holds two bits: a shift bit that sits on the path, and an update bit behind it. While the update bit is 0 the cell is closed: only its own shift bit lies between upstream scan-in and scan-out. Writing a 1 into the update bit opens the cell. A lower segment, such as an instrument register or further cells, is then spliced in. The shift bit then takes its data from that segment's return port. The cell also drives a select line down to the segment so that the segment takes part in capture, shift and update.

The host can only know how many bits to shift after it knows what it last wrote into the update bits of every cell on the path. A network is opened in steps. A short scan opens one cell. The next, longer scan then reaches the segment behind it. The shift bit changes on the rising edge of the test clock. The scan output is relaunched on the falling edge, so a chain of cells and segments has no hold race.

Top module: `sib_cell`

## Requirements
- R1: After reset the shift bit, the update bit, `scan_out` and `seg_select` are all 0, so the cell starts closed.
- R2: A rising clock edge with `sel` and `capture_en` high loads the capture constant 0 into the shift bit. Capture takes priority over shift.
- R3: While the update bit is 0, a rising edge with `sel` and `shift_en` high (and `capture_en` low) loads `scan_in` into the shift bit.
- R4: While the update bit is 1, a shift loads `seg_return` into the shift bit instead of `scan_in`.
- R5: The update bit takes the shift bit's value on a rising edge with `sel` and `update_en` high, and keeps its value on every other edge.
- R6: `seg_select` is high exactly when `sel` is high and the update bit is 1. It follows `sel` with no clock delay.
- R7: `scan_out` shows the shift bit's value from the falling edge that follows the rising edge that changed it. Between that rising edge and that falling edge it keeps its old value.
- R8: While `sel` is low, `capture_en`, `shift_en` and `update_en` have no effect. `scan_out` keeps its value and so does `seg_select` once `sel` returns.
- R9: Two cells in series, with the first cell's segment a 4-bit register fed from upstream scan-in, start as a 2-bit path. Shifting value 2 (binary 10, LSB first) and updating opens only the first cell. The path is then 6 bits long.
- R10: With the first cell open, shifting value 34 (binary 100010, LSB first) and updating sets bit 0 of the segment's update register. The entry bit nearest upstream is the sensor enable. The first cell stays open and the second stays closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; shift and update on rising edge, launch on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Cell select from the access port or the parent cell |
| capture_en | input | 1 | Capture enable |
| shift_en | input | 1 | Shift enable |
| update_en | input | 1 | Update enable |
| scan_in | input | 1 | Serial data from upstream |
| seg_return | input | 1 | Serial return from the inserted segment |
| scan_out | output | 1 | Serial data downstream, launched on the falling edge |
| seg_select | output | 1 | Select driven to the inserted segment |

## Verification
The shift bit and the update bit move on a rising edge. `scan_out` reflects the new shift bit only half a period later, at the falling edge. `seg_select` responds to `sel` at once and to an update on the same rising edge. Each bench step therefore drives inputs just after a falling edge and samples everything 1 ns after the next falling edge. The launch delay is checked separately by a sample taken 1 ns after the rising edge, where the old value must still show. In the chain tests, path length is measured by the step on which a single marker bit first shows at the far scan output: step 2 when closed, step 6 when the first cell is open.

// File: rtl/sib_pkg.sv
package sib_pkg;

  typedef enum logic [1:0] {
    SIB_HOLD    = 2'd0,
    SIB_CAPTURE = 2'd1,
    SIB_SHIFT   = 2'd2
  } sib_op_e;

  // Capture outranks shift; an unselected cell holds.
  function automatic sib_op_e sib_decode(input logic sel,
                                         input logic cap,
                                         input logic sh);
    if (!sel)     return SIB_HOLD;
    else if (cap) return SIB_CAPTURE;
    else if (sh)  return SIB_SHIFT;
    else          return SIB_HOLD;
  endfunction

  // Source of the shift bit: segment return when open, upstream when closed.
  function automatic logic sib_pick(input logic open_q,
                                    input logic up_in,
                                    input logic ret_in);
    return open_q ? ret_in : up_in;
  endfunction

  function automatic logic sib_next(input sib_op_e op,
                                    input logic    cur,
                                    input logic    din,
                                    input logic    cap_val);
    case (op)
      SIB_CAPTURE: return cap_val;
      SIB_SHIFT:   return din;
      default:     return cur;
    endcase
  endfunction

endpackage

// File: rtl/sib_ctrl.sv
module sib_ctrl
  import sib_pkg::*;
(
  input  logic    sel,
  input  logic    capture_en,
  input  logic    shift_en,
  input  logic    update_en,
  output sib_op_e op,
  output logic    cap_fire,
  output logic    shift_fire,
  output logic    upd_fire
);
  always_comb begin
    op         = sib_decode(sel, capture_en, shift_en);
    cap_fire   = (op == SIB_CAPTURE);
    shift_fire = (op == SIB_SHIFT);
    upd_fire   = sel & update_en;
  end
endmodule

// File: rtl/sib_shift_stage.sv
module sib_shift_stage
  import sib_pkg::*;
#(
  parameter logic RESET_VAL   = 1'b0,
  parameter logic CAPTURE_VAL = 1'b0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  sib_op_e op,
  input  logic    open_q,
  input  logic    up_in,
  input  logic    ret_in,
  output logic    bit_q
);
  logic src;

  always_comb src = sib_pick(open_q, up_in, ret_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= RESET_VAL;
    else        bit_q <= sib_next(op, bit_q, src, CAPTURE_VAL);
  end
endmodule

// File: rtl/sib_update_stage.sv
module sib_update_stage #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic din,
  output logic upd_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    upd_q <= RESET_VAL;
    else if (load) upd_q <= din;
  end
endmodule

// File: rtl/sib_launch.sv
module sib_launch #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) dout <= RESET_VAL;
    else        dout <= din;
  end
endmodule

// File: rtl/sib_cell.sv
module sib_cell
  import sib_pkg::*;
#(
  parameter logic RESET_VAL   = 1'b0,
  parameter logic CAPTURE_VAL = 1'b0
) (
  input  logic tck,
  input  logic rst_n,
  input  logic sel,
  input  logic capture_en,
  input  logic shift_en,
  input  logic update_en,
  input  logic scan_in,
  input  logic seg_return,
  output logic scan_out,
  output logic seg_select
);
  sib_op_e op;
  logic    cap_fire;
  logic    shift_fire;
  logic    upd_fire;
  logic    shift_bit;
  logic    update_bit;

  sib_ctrl u_ctrl (
    .sel        (sel),
    .capture_en (capture_en),
    .shift_en   (shift_en),
    .update_en  (update_en),
    .op         (op),
    .cap_fire   (cap_fire),
    .shift_fire (shift_fire),
    .upd_fire   (upd_fire)
  );

  sib_shift_stage #(
    .RESET_VAL   (RESET_VAL),
    .CAPTURE_VAL (CAPTURE_VAL)
  ) u_shift (
    .clk    (tck),
    .rst_n  (rst_n),
    .op     (op),
    .open_q (update_bit),
    .up_in  (scan_in),
    .ret_in (seg_return),
    .bit_q  (shift_bit)
  );

  sib_update_stage #(
    .RESET_VAL (RESET_VAL)
  ) u_update (
    .clk   (tck),
    .rst_n (rst_n),
    .load  (upd_fire),
    .din   (shift_bit),
    .upd_q (update_bit)
  );

  sib_launch #(
    .RESET_VAL (RESET_VAL)
  ) u_launch (
    .clk   (tck),
    .rst_n (rst_n),
    .din   (shift_bit),
    .dout  (scan_out)
  );

  assign seg_select = sel & update_bit;
endmodule

// File: rtl/sib_cell_chk.sv
module sib_cell_chk #(
  parameter logic CAPTURE_VAL = 1'b0
) (
  input logic tck,
  input logic rst_n,
  input logic sel,
  input logic scan_in,
  input logic seg_return,
  input logic scan_out,
  input logic seg_select,
  input logic cap_fire,
  input logic shift_fire,
  input logic upd_fire,
  input logic shift_bit,
  input logic update_bit
);
  // R2
  a_r2_capture_const: assert property (@(posedge tck) disable iff (!rst_n)
    cap_fire |=> (shift_bit == CAPTURE_VAL));

  // R3
  a_r3_closed_upstream: assert property (@(posedge tck) disable iff (!rst_n)
    (shift_fire && !update_bit) |=> (shift_bit == $past(scan_in)));

  // R4
  a_r4_open_return: assert property (@(posedge tck) disable iff (!rst_n)
    (shift_fire && update_bit) |=> (shift_bit == $past(seg_return)));

  // R5
  a_r5_update_copy: assert property (@(posedge tck) disable iff (!rst_n)
    upd_fire |=> (update_bit == $past(shift_bit)));

  a_r5_update_hold: assert property (@(posedge tck) disable iff (!rst_n)
    !upd_fire |=> $stable(update_bit));

  // R6
  a_r6_no_select_when_idle: assert property (@(posedge tck) disable iff (!rst_n)
    !sel |-> !seg_select);

  // R7
  a_r7_launch_tracks: assert property (@(posedge tck) disable iff (!rst_n)
    scan_out == shift_bit);

  // R8
  a_r8_unselected_frozen: assert property (@(posedge tck) disable iff (!rst_n)
    !sel |=> ($stable(shift_bit) && $stable(update_bit)));
endmodule

bind sib_cell sib_cell_chk #(.CAPTURE_VAL(CAPTURE_VAL)) u_chk (
  .tck        (tck),
  .rst_n      (rst_n),
  .sel        (sel),
  .scan_in    (scan_in),
  .seg_return (seg_return),
  .scan_out   (scan_out),
  .seg_select (seg_select),
  .cap_fire   (cap_fire),
  .shift_fire (shift_fire),
  .upd_fire   (upd_fire),
  .shift_bit  (shift_bit),
  .update_bit (update_bit)
);

// File: tb/sib_cell_tb.sv
module sib_cell_tb;
  logic tck = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0;
  logic cap = 1'b0;
  logic sh = 1'b0;
  logic upd = 1'b0;
  logic tdi = 1'b0;
  logic direct_mode = 1'b1;
  logic ret_drv = 1'b0;

  logic so1, so2, ssel1, ssel2;
  logic ret_mux;
  logic [3:0] seg_sr, seg_up;
  logic seg_so;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 tck = ~tck;   // 200 MHz

  assign ret_mux = direct_mode ? ret_drv : seg_so;

  sib_cell u_dut (
    .tck(tck), .rst_n(rst_n), .sel(sel), .capture_en(cap), .shift_en(sh),
    .update_en(upd), .scan_in(tdi), .seg_return(ret_mux),
    .scan_out(so1), .seg_select(ssel1)
  );

  sib_cell u_sib2 (
    .tck(tck), .rst_n(rst_n), .sel(sel), .capture_en(cap), .shift_en(sh),
    .update_en(upd), .scan_in(so1), .seg_return(1'b0),
    .scan_out(so2), .seg_select(ssel2)
  );

  // 4-bit segment behind the first cell: entry bit 0 from upstream scan-in,
  // exit bit 3, bit 0 of the update register is the sensor enable.
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      seg_sr <= '0;
      seg_up <= '0;
    end else if (ssel1) begin
      if (cap)     seg_sr <= '0;
      else if (sh) seg_sr <= {seg_sr[2:0], tdi};
      if (upd)     seg_up <= seg_sr;
    end
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) seg_so <= 1'b0;
    else        seg_so <= seg_sr[3];
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  // Drive after a falling edge, clock once, sample 1 ns after the next fall.
  task automatic step(input logic s, input logic c, input logic h,
                      input logic u, input logic d, input logic r);
    sel = s; cap = c; sh = h; upd = u; tdi = d; ret_drv = r;
    @(posedge tck);
    @(negedge tck);
    #1;
    cap = 1'b0; sh = 1'b0; upd = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sel = 1'b0; cap = 1'b0; sh = 1'b0; upd = 1'b0; tdi = 1'b0; ret_drv = 1'b0;
    repeat (3) @(negedge tck);
    #1 rst_n = 1'b1;
  endtask

  task automatic t_reset();
    check("R1 scan_out", so1, 1'b0);
    sel = 1'b1; #1;
    check("R1 seg_select", ssel1, 1'b0);
  endtask

  task automatic t_closed_and_launch();
    step(1, 0, 1, 0, 1, 0);
    check("R3 closed takes scan_in=1", so1, 1'b1);
    sel = 1'b1; sh = 1'b1; tdi = 1'b0;
    @(posedge tck); #1;
    check("R7 old value before fall", so1, 1'b1);
    @(negedge tck); #1;
    sh = 1'b0;
    check("R7 new value after fall", so1, 1'b0);
    check("R3 closed takes scan_in=0", so1, 1'b0);
  endtask

  task automatic t_capture();
    step(1, 0, 1, 0, 1, 0);
    check("R3 load 1 before capture", so1, 1'b1);
    step(1, 1, 1, 0, 1, 0);
    check("R2 capture 0 outranks shift", so1, 1'b0);
  endtask

  task automatic t_update();
    step(1, 0, 1, 0, 1, 0);
    check("R5 no update yet", ssel1, 1'b0);
    step(1, 0, 0, 1, 0, 0);
    check("R5 update opens", ssel1, 1'b1);
    sel = 1'b0; #1;
    check("R6 select low drops seg_select", ssel1, 1'b0);
    sel = 1'b1; #1;
    check("R6 select high restores seg_select", ssel1, 1'b1);
  endtask

  task automatic t_open_return();
    direct_mode = 1'b1;
    step(1, 0, 1, 0, 0, 1);
    check("R4 open takes return=1", so1, 1'b1);
    step(1, 0, 1, 0, 1, 0);
    check("R4 open ignores scan_in", so1, 1'b0);
  endtask

  task automatic t_unselected();
    step(0, 0, 1, 0, 1, 1);
    check("R8 shift ignored", so1, 1'b0);
    step(0, 0, 0, 1, 0, 0);
    sel = 1'b1; #1;
    check("R8 update ignored", ssel1, 1'b1);
    step(1, 0, 1, 0, 0, 1);
    check("R8 set bit before capture", so1, 1'b1);
    step(0, 1, 0, 0, 0, 0);
    check("R8 capture ignored", so1, 1'b1);
  endtask

  task automatic t_chain_open_first();
    do_reset();
    direct_mode = 1'b0;
    step(1, 1, 0, 0, 0, 0);
    step(1, 0, 1, 0, 1, 0);
    check("R9 closed path step1", so2, 1'b0);
    step(1, 0, 1, 0, 0, 0);
    check("R9 closed path length 2", so2, 1'b1);
    // value 2 LSB first: 0 then 1
    step(1, 0, 1, 0, 0, 0);
    step(1, 0, 1, 0, 1, 0);
    step(1, 0, 0, 1, 0, 0);
    check("R9 first cell open", ssel1, 1'b1);
    check("R9 second cell closed", ssel2, 1'b0);
    step(1, 1, 0, 0, 0, 0);
    for (int i = 1; i <= 6; i++) begin
      step(1, 0, 1, 0, (i == 1), 0);
      if (i == 5) check("R9 marker not out at step 5", so2, 1'b0);
      if (i == 6) check("R9 open path length 6", so2, 1'b1);
    end
  endtask

  task automatic t_chain_enable_sensor();
    logic [5:0] pat = 6'b100010;
    check("R10 sensor off before", seg_up[0], 1'b0);
    for (int i = 0; i < 6; i++) step(1, 0, 1, 0, pat[i], 0);
    step(1, 0, 0, 1, 0, 0);
    check("R10 sensor enabled", seg_up[0], 1'b1);
    check("R10 first cell stays open", ssel1, 1'b1);
    check("R10 second cell stays closed", ssel2, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset();
    t_closed_and_launch();
    t_capture();
    t_update();
    t_open_return();
    t_unselected();
    t_chain_open_first();
    t_chain_enable_sensor();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule